// File: doc/BRIEF.md
# Per-Flow Multipath Route Selector

This block sits at the ingress of a fabric that offers several parallel routes to the same destination. For each arriving packet it names the route that the whole packet will take. It never splits a packet into pieces. Each packet arrives as a one-cycle descriptor that carries a flow number. Alongside it, the block sees the free credit count that the downstream buffer of every route currently advertises. A static two-bit policy input picks one of four ways of choosing.

The first policy rotates a private pointer for each flow. The second lets each flow use any route, provided the imbalance it has built up on that route stays under a programmable limit. The third takes whichever route has the most free credits and keeps no memory at all. The fourth pins every flow to a route derived from its number, so the packets of a flow stay in order.

The first two policies spread each flow over the routes on its own, rather than only the total load. To do this they read and write a small state table indexed by flow number. A route that shows zero credits is never named. When no route can be named, the packet gets no answer.

Top module: `flow_path_selector`

## Requirements
- R1: After reset `selValid` and `selPath` are 0. A packet that is accepted at a clock edge produces `selValid` high for exactly the next cycle, with its route on `selPath`. `selValid` is low in every other cycle.
- R2: A route whose 4-bit credit field is 0 is never named, in any policy. If the allowed choice set is empty, the packet gets no answer and the flow's state is left unchanged.
- R3: Policy 0 (rotate): each flow has a pointer that is 0 after reset. The route chosen is the first credited route at or after the pointer, in increasing circular order. The pointer then becomes the chosen route plus one, modulo 4.
- R4: The state of one flow (pointer and counters) is never changed by the packets of another flow.
- R5: Policy 1 (bounded): each flow has four signed counters that are 0 after reset. A route is eligible when it has credits and its counter is less than `imbBound`. The lowest-numbered eligible route wins. The chosen route's counter then rises by one, saturating at +3. If after that all four counters are above zero, all four drop by one.
- R6: Policy 1 with no eligible route: the credited route with the smallest counter is chosen (lowest number on a tie), and the counters update as in R5.
- R7: Policy 2 (most credits): the credited route with the largest credit field is chosen, with the lowest number winning a tie. No per-flow state changes.
- R8: Policy 3 (pinned): the route is flow[3:2] XOR flow[1:0]. If that route has zero credits, the packet gets no answer.
- R9: The rotate pointers change only under policy 0, and the counters change only under policy 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pktValid | input | 1 | Packet descriptor present this cycle |
| pktFlow | input | 4 | Flow number of the packet |
| pathCredits | input | 16 | Free credits per route; route p in bits [4p+3:4p] |
| selMode | input | 2 | Policy: 0 rotate, 1 bounded, 2 most credits, 3 pinned |
| imbBound | input | 2 | Counter limit for policy 1 |
| selValid | output | 1 | Route answer valid |
| selPath | output | 2 | Chosen route number |

## Verification
Two things land on the same edge when packets of one flow arrive back to back. The edge that registers a flow's answer also writes that flow's pointer or counters. The next packet of the same flow must then read the freshly written entry. The bench provokes this with uninterrupted runs of a single flow under policies 0 and 1, some of them mixed with routes that have no credits. Every answer is judged against a model that applies each update before it forms the next expectation.

// File: rtl/flow_path_selector_pkg.sv
`timescale 1ns/1ps
package flow_path_selector_pkg;
  typedef enum logic [1:0] {
    MODE_ROTATE  = 2'd0,
    MODE_BOUNDED = 2'd1,
    MODE_CREDITS = 2'd2,
    MODE_PINNED  = 2'd3
  } selMode_e;

  typedef struct packed {
    logic fire;
    logic ptrWr;
    logic imbWr;
  } selStrobe_t;
endpackage

// File: rtl/flow_path_selector_ctrl.sv
`timescale 1ns/1ps
module flow_path_selector_ctrl
  import flow_path_selector_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pktValid,
  input  selMode_e   mode,
  input  logic       pickOk,
  output selStrobe_t strobe,
  output logic       selValid
);
  always_comb begin
    strobe.fire  = pktValid & pickOk;
    strobe.ptrWr = strobe.fire & (mode == MODE_ROTATE);
    strobe.imbWr = strobe.fire & (mode == MODE_BOUNDED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selValid <= 1'b0;
    else       selValid <= strobe.fire;
  end

  // R1
  sel_after_pkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> $past(pktValid));
endmodule

// File: rtl/flow_path_selector_dp.sv
`timescale 1ns/1ps
module flow_path_selector_dp
  import flow_path_selector_pkg::*;
#(
  parameter int NUM_PATHS = 4,
  parameter int NUM_FLOWS = 16,
  parameter int CRED_W    = 4,
  parameter int IMB_W     = 3,
  parameter int PATH_W    = $clog2(NUM_PATHS),
  parameter int FLOW_W    = $clog2(NUM_FLOWS)
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [FLOW_W-1:0]           pktFlow,
  input  logic [NUM_PATHS*CRED_W-1:0] pathCredits,
  input  selMode_e                    mode,
  input  logic [IMB_W-2:0]            imbBound,
  input  selStrobe_t                  strobe,
  output logic                        pickOk,
  output logic [PATH_W-1:0]           selPath
);
  localparam int FOLDS = (FLOW_W + PATH_W - 1) / PATH_W;
  typedef logic signed [IMB_W-1:0] imb_t;
  localparam imb_t IMB_MAX = imb_t'({1'b0, {(IMB_W-1){1'b1}}});

  logic [PATH_W-1:0] ptrTab [NUM_FLOWS];
  imb_t              imbTab [NUM_FLOWS][NUM_PATHS];

  logic [NUM_PATHS-1:0] credOk, credOkQ;
  logic [CRED_W-1:0]    credOf [NUM_PATHS];
  imb_t                 curImb [NUM_PATHS];
  imb_t                 nxtImb [NUM_PATHS];
  imb_t                 wrapImb [NUM_PATHS];
  logic [PATH_W-1:0]    curPtr;
  logic [PATH_W-1:0]    pickPath;

  assign curPtr = ptrTab[pktFlow];

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    assign credOf[g] = pathCredits[g*CRED_W +: CRED_W];
    assign credOk[g] = |credOf[g];
    assign curImb[g] = imbTab[pktFlow][g];
    // R5
    imb_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
      curImb[g] >= imb_t'(0));
  end

  // rotate policy
  logic              rrOk;
  logic [PATH_W-1:0] rrPath;
  always_comb begin
    rrOk   = 1'b0;
    rrPath = '0;
    for (int k = NUM_PATHS - 1; k >= 0; k--) begin
      if (credOk[curPtr + PATH_W'(k)]) begin
        rrOk   = 1'b1;
        rrPath = curPtr + PATH_W'(k);
      end
    end
  end

  // bounded-imbalance policy
  imb_t              bndLimit;
  logic              eligOk, minOk;
  logic [PATH_W-1:0] eligPath, minPath, bndPath;
  imb_t              minVal;
  assign bndLimit = imb_t'({1'b0, imbBound});
  always_comb begin
    eligOk   = 1'b0;
    eligPath = '0;
    for (int k = NUM_PATHS - 1; k >= 0; k--) begin
      if (credOk[k] && (curImb[k] < bndLimit)) begin
        eligOk   = 1'b1;
        eligPath = PATH_W'(k);
      end
    end
    minOk   = 1'b0;
    minPath = '0;
    minVal  = IMB_MAX;
    for (int k = 0; k < NUM_PATHS; k++) begin
      if (credOk[k] && (!minOk || (curImb[k] < minVal))) begin
        minOk   = 1'b1;
        minPath = PATH_W'(k);
        minVal  = curImb[k];
      end
    end
    bndPath = eligOk ? eligPath : minPath;
  end

  logic allPos;
  always_comb begin
    for (int k = 0; k < NUM_PATHS; k++) begin
      if ((PATH_W'(k) == bndPath) && (curImb[k] != IMB_MAX))
        nxtImb[k] = curImb[k] + imb_t'(1);
      else
        nxtImb[k] = curImb[k];
    end
    allPos = 1'b1;
    for (int k = 0; k < NUM_PATHS; k++)
      if (nxtImb[k] <= imb_t'(0)) allPos = 1'b0;
    for (int k = 0; k < NUM_PATHS; k++)
      wrapImb[k] = allPos ? (nxtImb[k] - imb_t'(1)) : nxtImb[k];
  end

  // most-credits policy
  logic              bestOk;
  logic [PATH_W-1:0] bestPath;
  logic [CRED_W-1:0] bestVal;
  always_comb begin
    bestOk   = 1'b0;
    bestPath = '0;
    bestVal  = '0;
    for (int k = 0; k < NUM_PATHS; k++) begin
      if (credOk[k] && (!bestOk || (credOf[k] > bestVal))) begin
        bestOk   = 1'b1;
        bestPath = PATH_W'(k);
        bestVal  = credOf[k];
      end
    end
  end

  // pinned policy
  logic [FOLDS*PATH_W-1:0] flowPad;
  logic [PATH_W-1:0]       hashPath;
  assign flowPad = (FOLDS*PATH_W)'(pktFlow);
  always_comb begin
    hashPath = '0;
    for (int i = 0; i < FOLDS; i++)
      hashPath = hashPath ^ flowPad[i*PATH_W +: PATH_W];
  end

  always_comb begin
    unique case (mode)
      MODE_ROTATE:  begin pickOk = rrOk;             pickPath = rrPath;   end
      MODE_BOUNDED: begin pickOk = minOk;            pickPath = bndPath;  end
      MODE_CREDITS: begin pickOk = bestOk;           pickPath = bestPath; end
      default:      begin pickOk = credOk[hashPath]; pickPath = hashPath; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPath <= '0;
      credOkQ <= '0;
      for (int f = 0; f < NUM_FLOWS; f++) begin
        ptrTab[f] <= '0;
        for (int p = 0; p < NUM_PATHS; p++) imbTab[f][p] <= '0;
      end
    end else begin
      credOkQ <= credOk;
      if (strobe.fire)  selPath <= pickPath;
      if (strobe.ptrWr) ptrTab[pktFlow] <= pickPath + PATH_W'(1);
      if (strobe.imbWr)
        for (int p = 0; p < NUM_PATHS; p++) imbTab[pktFlow][p] <= wrapImb[p];
    end
  end

  // R2
  fire_credited_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> credOkQ[selPath]);
  // R2
  no_credit_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (credOk == '0) |-> !strobe.fire);
  // R8
  pinned_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && (mode == MODE_PINNED)) |=> (selPath == $past(hashPath)));
  // R9
  state_write_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.ptrWr && strobe.imbWr));
endmodule

// File: rtl/flow_path_selector.sv
`timescale 1ns/1ps
module flow_path_selector
  import flow_path_selector_pkg::*;
#(
  parameter int NUM_PATHS = 4,
  parameter int NUM_FLOWS = 16,
  parameter int CRED_W    = 4,
  parameter int IMB_W     = 3,
  parameter int PATH_W    = $clog2(NUM_PATHS),
  parameter int FLOW_W    = $clog2(NUM_FLOWS)
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pktValid,
  input  logic [FLOW_W-1:0]           pktFlow,
  input  logic [NUM_PATHS*CRED_W-1:0] pathCredits,
  input  logic [1:0]                  selMode,
  input  logic [IMB_W-2:0]            imbBound,
  output logic                        selValid,
  output logic [PATH_W-1:0]           selPath
);
  selStrobe_t strobe;
  logic       pickOk;
  selMode_e   mode;

  assign mode = selMode_e'(selMode);

  flow_path_selector_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pktValid (pktValid),
    .mode     (mode),
    .pickOk   (pickOk),
    .strobe   (strobe),
    .selValid (selValid)
  );

  flow_path_selector_dp #(
    .NUM_PATHS (NUM_PATHS),
    .NUM_FLOWS (NUM_FLOWS),
    .CRED_W    (CRED_W),
    .IMB_W     (IMB_W),
    .PATH_W    (PATH_W),
    .FLOW_W    (FLOW_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pktFlow     (pktFlow),
    .pathCredits (pathCredits),
    .mode        (mode),
    .imbBound    (imbBound),
    .strobe      (strobe),
    .pickOk      (pickOk),
    .selPath     (selPath)
  );
endmodule

// File: tb/flow_path_selector_tb.sv
`timescale 1ns/1ps
module flow_path_selector_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic [3:0]  pktFlow = '0;
  logic [15:0] pathCredits = '0;
  logic [1:0]  selMode = 2'd0;
  logic [1:0]  imbBound = 2'd0;
  logic        selValid;
  logic [1:0]  selPath;

  flow_path_selector u_dut (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktFlow(pktFlow),
    .pathCredits(pathCredits), .selMode(selMode), .imbBound(imbBound),
    .selValid(selValid), .selPath(selPath)
  );

  always #5 clk = ~clk;

  typedef struct {
    bit    expValid;
    int    expPath;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int ptrM [16];
  int imbM [16][4];
  bit done = 1'b0;

  // reference model of one packet, applied in arrival order
  task automatic sendPkt(input int flow, input int c0, input int c1,
                         input int c2, input int c3, input string tag);
    int  cr [4];
    bit  ok;
    int  path;
    int  best;
    bit  allPos;
    expItem_t it;
    cr[0] = c0; cr[1] = c1; cr[2] = c2; cr[3] = c3;
    ok = 1'b0; path = 0;
    case (selMode)
      2'd0: begin
        for (int k = 3; k >= 0; k--)
          if (cr[(ptrM[flow] + k) % 4] > 0) begin ok = 1'b1; path = (ptrM[flow] + k) % 4; end
        if (ok) ptrM[flow] = (path + 1) % 4;
      end
      2'd1: begin
        for (int k = 3; k >= 0; k--)
          if (cr[k] > 0 && imbM[flow][k] < int'(imbBound)) begin ok = 1'b1; path = k; end
        if (!ok) begin
          best = 99;
          for (int k = 0; k < 4; k++)
            if (cr[k] > 0 && imbM[flow][k] < best) begin ok = 1'b1; path = k; best = imbM[flow][k]; end
        end
        if (ok) begin
          if (imbM[flow][path] < 3) imbM[flow][path]++;
          allPos = 1'b1;
          for (int k = 0; k < 4; k++) if (imbM[flow][k] <= 0) allPos = 1'b0;
          if (allPos) for (int k = 0; k < 4; k++) imbM[flow][k]--;
        end
      end
      2'd2: begin
        best = 0;
        for (int k = 0; k < 4; k++)
          if (cr[k] > best) begin ok = 1'b1; path = k; best = cr[k]; end
      end
      default: begin
        path = ((flow >> 2) ^ flow) & 3;
        ok   = cr[path] > 0;
      end
    endcase
    @(negedge clk);
    pktValid = 1'b1;
    pktFlow  = 4'(flow);
    for (int k = 0; k < 4; k++) pathCredits[k*4 +: 4] = 4'(cr[k]);
    it.expValid = ok; it.expPath = path; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    expItem_t it;
    @(negedge clk);
    pktValid = 1'b0;
    it.expValid = 1'b0; it.expPath = 0; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic setMode(input int m, input int bnd);
    idle("R1");
    selMode  = 2'(m);
    imbBound = 2'(bnd);
  endtask

  // monitor: compares each registered answer one edge after its packet
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (selValid !== it.expValid ||
            (it.expValid && int'(selPath) != it.expPath)) begin
          errors++;
          $display("FAIL %s valid=%0b path=%0d expected valid=%0b path=%0d",
                   it.tag, selValid, selPath, it.expValid, it.expPath);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 16; f++) begin
      ptrM[f] = 0;
      for (int p = 0; p < 4; p++) imbM[f][p] = 0;
    end
    #1;
    checks++;
    if (selValid !== 1'b0 || selPath !== 2'd0) begin
      errors++;
      $display("FAIL R1 reset valid=%0b path=%0d expected valid=0 path=0", selValid, selPath);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3 rotation of one flow; R4 a second flow starts from its own pointer
    setMode(0, 0);
    sendPkt(3, 5, 5, 5, 5, "R3");
    sendPkt(3, 5, 5, 5, 5, "R3");
    sendPkt(7, 5, 5, 5, 5, "R4");
    sendPkt(3, 5, 5, 5, 5, "R3");
    sendPkt(3, 5, 5, 5, 5, "R3");
    sendPkt(3, 5, 5, 5, 5, "R3");
    sendPkt(7, 5, 5, 5, 5, "R4");
    // R2 skip an empty route, then no answer with no credits at all
    sendPkt(3, 5, 0, 5, 5, "R2");
    sendPkt(3, 0, 0, 0, 0, "R2");
    idle("R1");
    sendPkt(3, 5, 5, 5, 5, "R2");
    sendPkt(3, 0, 0, 2, 0, "R2");

    // R7 most credits, ties to lowest
    setMode(2, 0);
    sendPkt(3, 3, 9, 9, 2, "R7");
    sendPkt(3, 4, 4, 4, 4, "R7");
    sendPkt(3, 0, 0, 0, 7, "R7");
    sendPkt(3, 0, 0, 0, 0, "R2");
    // R9 rotate pointer untouched by the other policy
    setMode(0, 0);
    sendPkt(3, 5, 5, 5, 5, "R9");

    // R8 pinned routes for every flow
    setMode(3, 0);
    for (int f = 0; f < 16; f++) sendPkt(f, 5, 5, 5, 5, "R8");
    sendPkt(6, 5, 5, 5, 0, "R8");
    sendPkt(6, 5, 5, 5, 1, "R8");

    // R5 bounded imbalance, back to back on one flow
    setMode(1, 2);
    for (int i = 0; i < 10; i++) sendPkt(9, 5, 5, 5, 5, "R5");
    sendPkt(9, 0, 5, 5, 5, "R5");
    sendPkt(4, 5, 5, 5, 5, "R4");
    // R6 no route eligible
    setMode(1, 0);
    for (int i = 0; i < 6; i++) sendPkt(10, 5, 5, 0, 5, "R6");
    sendPkt(10, 0, 0, 0, 0, "R2");
    setMode(1, 1);
    for (int i = 0; i < 5; i++) sendPkt(9, 0, 5, 5, 5, "R5");
    // R9 counters untouched by the rotate policy
    setMode(0, 1);
    sendPkt(9, 5, 5, 5, 5, "R9");
    setMode(1, 1);
    sendPkt(9, 5, 5, 5, 5, "R9");

    idle("R1");
    idle("R1");
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule